// File: doc/BRIEF.md
# Dual Clock Frequency Comparator

This block decides whether a monitored clock runs within a chosen tolerance of a reference clock. Software loads three seeds over a simple register port on the system clock and then starts a single measurement. A reference down-counter runs on the reference clock. A monitor down-counter runs on the monitored clock. When the reference counter runs out, a window counter, also clocked by the reference, opens an acceptance window. The measurement passes only if the monitor counter runs out while that window is open.

Each measurement has one of two outcomes. A pass sets the done status bit and raises a one-cycle `irq_done` pulse. A failure sets the error status bit, which drives the level output `err_out`. A failure happens when the monitor runs out too early or too late, when the monitored clock is missing, or when the reference clock is missing. A missing reference clock is caught by a system-clock timeout on a divided reference heartbeat.

The expiry event crosses between clock domains as a toggle through two-flop synchronizers. Each expiry carries a run tag, so that an expiry left over from an earlier run is discarded.

Top module: `clkmon_top`

## Requirements
- R1: After reset, every seed register and the status register read 0, the timeout register reads 1024, and `irq_done` and `err_out` are low.
- R2: If the monitor counter expires while the window counter is counting down, the done bit (status bit 1) is set and `irq_done` pulses high for exactly one system cycle. The error bit stays clear.
- R3: If the monitor counter expires before the reference counter has expired, the run ends with the error bit (status bit 0) set and no `irq_done` pulse.
- R4: If the reference counter and the window counter both expire before the monitor counter, the run ends with an error. This also covers a stopped monitored clock.
- R5: `err_out` is high exactly while the error status bit is set. A run never ends with both the done and error bits being set.
- R6: The status register is at byte offset 0x14, with bit 0 = error, bit 1 = done and bit 2 = busy. Writing 1 to bit 0 or bit 1 clears that bit. Writing 0 leaves it unchanged.
- R7: Writing 1 to bit 0 at offset 0x00 starts one measurement only when busy is clear. A start written while busy has no effect, and each accepted start produces exactly one outcome.
- R8: The reference seed (0x04, 20 bits), window seed (0x08, 16 bits), monitor seed (0x0C, 20 bits) and timeout limit (0x10, 16 bits) ignore writes while busy is set.
- R9: If no reference heartbeat reaches the system clock for the number of system cycles held in the timeout register, the run ends with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port and status |
| rst_n | input | 1 | Active-low asynchronous reset, all domains |
| ref_clk | input | 1 | Reference clock |
| mon_clk | input | 1 | Monitored clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_done | output | 1 | One-cycle pulse when a run passes |
| err_out | output | 1 | High while the error status bit is set |

## Verification
The hardest case to reach from the ports is a late monitor expiry that arrives from a previous run while a new run's window is open. Only the run tag keeps this event from being counted as a pass. The bench creates it by stopping the monitored clock during one run, letting that run fail on its window, and then restarting the clock. The monitor side then finishes the stale run. The next measurement must still give its own correct verdict. Random cases draw both clock periods and the seeds, then aim the monitor expiry early, inside the window or late. A bench model predicts the verdict and sets aside draws that fall too close to a window edge.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
  typedef enum logic [1:0] {RS_IDLE, RS_COUNT, RS_WIN, RS_REPORT} ref_state_e;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_SEED_REF = 8'h04;
  localparam logic [7:0] OFS_SEED_WIN = 8'h08;
  localparam logic [7:0] OFS_SEED_MON = 8'h0C;
  localparam logic [7:0] OFS_TMO      = 8'h10;
  localparam logic [7:0] OFS_STAT     = 8'h14;

  localparam int STAT_ERR  = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_BUSY = 2;

  // a counter on its final tick (a zero seed behaves as one)
  function automatic logic last_tick(input logic [31:0] c);
    return c <= 32'd1;
  endfunction

  function automatic logic [31:0] step_down(input logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction
endpackage

// File: rtl/clkmon_sync.sv
`timescale 1ns/1ps
module clkmon_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/clkmon_mon_side.sv
`timescale 1ns/1ps
module clkmon_mon_side import clkmon_pkg::*; #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tgl_a,
  input  logic [CW-1:0] seed,
  output logic          exp_tgl,
  output logic          run_tag
);
  logic          st_s, st_q, load_evt, run_q, cnt_last;
  logic [CW-1:0] cnt_q;

  clkmon_sync #(.W(1)) u_st_sync (.clk(clk), .rst_n(rst_n), .d(start_tgl_a), .q(st_s));

  assign load_evt = st_s ^ st_q;
  assign cnt_last = last_tick(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      exp_tgl <= 1'b0;
      run_tag <= 1'b0;
    end else begin
      st_q <= st_s;
      if (load_evt) begin
        cnt_q   <= seed;
        run_q   <= 1'b1;
        run_tag <= st_s;
      end else if (run_q) begin
        cnt_q <= CW'(step_down(32'(cnt_q)));
        if (cnt_last) begin
          run_q   <= 1'b0;
          exp_tgl <= ~exp_tgl;
        end
      end
    end
  end

  // R7: once stopped, the monitor counter stays put until the next load
  p_cnt1_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_evt) |=> $stable(cnt_q));
  // R7: the run tag only changes on a load
  p_tag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(run_tag));
endmodule

// File: rtl/clkmon_ref_side.sv
`timescale 1ns/1ps
module clkmon_ref_side import clkmon_pkg::*; #(
  parameter int CW     = 20,
  parameter int WW     = 16,
  parameter int HB_DIV = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tgl_a,
  input  logic [CW-1:0] seed_ref,
  input  logic [WW-1:0] seed_win,
  input  logic          mon_exp_a,
  input  logic          mon_tag_a,
  output logic          verdict_tgl,
  output logic          verdict_err,
  output logic          heartbeat
);
  ref_state_e        st_q;
  logic [2:0]        sy;
  logic              st_q1, ex_q, parity_q;
  logic              load_evt, mon_evt, cnt0_hit, win_hit, in_win;
  logic [CW-1:0]     cnt0_q;
  logic [WW-1:0]     win_q;
  logic [HB_DIV-1:0] hb_q;

  clkmon_sync #(.W(3)) u_sync (.clk(clk), .rst_n(rst_n),
    .d({mon_tag_a, mon_exp_a, start_tgl_a}), .q(sy));

  assign load_evt = sy[0] ^ st_q1;
  assign mon_evt  = (sy[1] ^ ex_q) && (sy[2] == parity_q);
  assign cnt0_hit = (st_q == RS_COUNT) && !mon_evt && last_tick(32'(cnt0_q));
  assign win_hit  = (st_q == RS_WIN) && !mon_evt && last_tick(32'(win_q));
  assign in_win   = (st_q == RS_WIN);
  assign heartbeat = hb_q[HB_DIV-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= RS_IDLE;
      st_q1       <= 1'b0;
      ex_q        <= 1'b0;
      parity_q    <= 1'b0;
      cnt0_q      <= '0;
      win_q       <= '0;
      verdict_tgl <= 1'b0;
      verdict_err <= 1'b0;
      hb_q        <= '0;
    end else begin
      st_q1 <= sy[0];
      ex_q  <= sy[1];
      hb_q  <= hb_q + 1'b1;
      unique case (st_q)
        RS_IDLE: if (load_evt) begin
          cnt0_q   <= seed_ref;
          win_q    <= seed_win;
          parity_q <= sy[0];
          st_q     <= RS_COUNT;
        end
        RS_COUNT: begin
          if (mon_evt) begin
            verdict_err <= 1'b1;
            st_q        <= RS_REPORT;
          end else begin
            cnt0_q <= CW'(step_down(32'(cnt0_q)));
            if (cnt0_hit) st_q <= RS_WIN;
          end
        end
        RS_WIN: begin
          if (mon_evt) begin
            verdict_err <= 1'b0;
            st_q        <= RS_REPORT;
          end else begin
            win_q <= WW'(step_down(32'(win_q)));
            if (win_hit) begin
              verdict_err <= 1'b1;
              st_q        <= RS_REPORT;
            end
          end
        end
        RS_REPORT: begin
          verdict_tgl <= ~verdict_tgl;
          st_q        <= RS_IDLE;
        end
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  // R4: the window only opens after the reference counter ran out
  p_win_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_win) |-> $past(cnt0_hit));
  // R3: a monitor expiry before the window leads straight to an error report
  p_early_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_COUNT && mon_evt) |=> (verdict_err && st_q == RS_REPORT));
  // R7: one verdict toggle per run, only from the report state
  p_report_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_tgl != $past(verdict_tgl)) |-> ($past(st_q) == RS_REPORT));
endmodule

// File: rtl/clkmon_regs.sv
`timescale 1ns/1ps
module clkmon_regs import clkmon_pkg::*; #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int W0 = 20,
  parameter int WW = 16,
  parameter int W1 = 20,
  parameter int TW = 16,
  parameter logic [TW-1:0] TMO_RST = TW'(1024)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [W0-1:0] seed_ref,
  output logic [WW-1:0] seed_win,
  output logic [W1-1:0] seed_mon,
  output logic          start_tgl,
  input  logic          verdict_tgl_a,
  input  logic          verdict_err_a,
  input  logic          hb_a,
  output logic          irq_done,
  output logic          err_out
);
  logic [2:0]    vs;
  logic          busy_q, err_q, done_q, vt_q, vt_q2, hb_q;
  logic [TW-1:0] tmo_lim_q, tmo_cnt_q;
  logic          verdict_evt, hb_evt, tmo_hit, set_done, set_err, start_go, cfg_we;

  clkmon_sync #(.W(3)) u_sync (.clk(clk), .rst_n(rst_n),
    .d({hb_a, verdict_err_a, verdict_tgl_a}), .q(vs));

  assign verdict_evt = vt_q ^ vt_q2;
  assign hb_evt      = vs[2] ^ hb_q;
  assign tmo_hit     = busy_q && !verdict_evt && !hb_evt &&
                       (({1'b0, tmo_cnt_q} + 1'b1) >= {1'b0, tmo_lim_q});
  assign set_done    = busy_q && verdict_evt && !vs[1];
  assign set_err     = busy_q && ((verdict_evt && vs[1]) || tmo_hit);
  assign start_go    = bus_wr && (bus_addr == AW'(OFS_CTRL)) && bus_wdata[0] && !busy_q;
  assign cfg_we      = bus_wr && !busy_q;
  assign err_out     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_ref  <= '0;
      seed_win  <= '0;
      seed_mon  <= '0;
      tmo_lim_q <= TMO_RST;
      tmo_cnt_q <= '0;
      start_tgl <= 1'b0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      irq_done  <= 1'b0;
      vt_q      <= 1'b0;
      vt_q2     <= 1'b0;
      hb_q      <= 1'b0;
    end else begin
      vt_q     <= vs[0];
      vt_q2    <= vt_q;
      hb_q     <= vs[2];
      irq_done <= set_done;
      if (cfg_we) begin
        if (bus_addr == AW'(OFS_SEED_REF)) seed_ref  <= bus_wdata[W0-1:0];
        if (bus_addr == AW'(OFS_SEED_WIN)) seed_win  <= bus_wdata[WW-1:0];
        if (bus_addr == AW'(OFS_SEED_MON)) seed_mon  <= bus_wdata[W1-1:0];
        if (bus_addr == AW'(OFS_TMO))      tmo_lim_q <= bus_wdata[TW-1:0];
      end
      if (bus_wr && bus_addr == AW'(OFS_STAT)) begin
        if (bus_wdata[STAT_ERR])  err_q  <= 1'b0;
        if (bus_wdata[STAT_DONE]) done_q <= 1'b0;
      end
      if (set_err)  err_q  <= 1'b1;
      if (set_done) done_q <= 1'b1;
      if (start_go) begin
        start_tgl <= ~start_tgl;
        busy_q    <= 1'b1;
        tmo_cnt_q <= '0;
      end else if (busy_q) begin
        if (set_err || set_done) busy_q <= 1'b0;
        if (hb_evt) tmo_cnt_q <= '0;
        else        tmo_cnt_q <= tmo_cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(OFS_SEED_REF): bus_rdata = DW'(seed_ref);
      AW'(OFS_SEED_WIN): bus_rdata = DW'(seed_win);
      AW'(OFS_SEED_MON): bus_rdata = DW'(seed_mon);
      AW'(OFS_TMO):      bus_rdata = DW'(tmo_lim_q);
      AW'(OFS_STAT): begin
        bus_rdata[STAT_ERR]  = err_q;
        bus_rdata[STAT_DONE] = done_q;
        bus_rdata[STAT_BUSY] = busy_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R2: the done interrupt is a single-cycle pulse
  p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  // R7: a done pulse only follows the end of a busy run
  p_irq_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> ($past(busy_q) && !busy_q));
  // R5: one outcome per run, never both
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> !set_err);
  // R8: configuration holds through a run
  p_seed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(seed_ref) && $stable(seed_win) &&
                                   $stable(seed_mon) && $stable(tmo_lim_q)));
  // R9: the timeout count never passes its limit
  p_tmo_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tmo_cnt_q < tmo_lim_q || tmo_lim_q == '0));
endmodule

// File: rtl/clkmon_top.sv
`timescale 1ns/1ps
module clkmon_top #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int W0     = 20,
  parameter int WW     = 16,
  parameter int W1     = 20,
  parameter int TW     = 16,
  parameter int HB_DIV = 3
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          mon_clk,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_done,
  output logic          err_out
);
  logic [W0-1:0] seed_ref;
  logic [WW-1:0] seed_win;
  logic [W1-1:0] seed_mon;
  logic start_tgl, verdict_tgl, verdict_err, heartbeat, mon_exp, mon_tag;

  clkmon_regs #(.AW(AW), .DW(DW), .W0(W0), .WW(WW), .W1(W1), .TW(TW)) u_regs (
    .clk(sys_clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seed_ref(seed_ref),
    .seed_win(seed_win), .seed_mon(seed_mon), .start_tgl(start_tgl),
    .verdict_tgl_a(verdict_tgl), .verdict_err_a(verdict_err), .hb_a(heartbeat),
    .irq_done(irq_done), .err_out(err_out));

  clkmon_ref_side #(.CW(W0), .WW(WW), .HB_DIV(HB_DIV)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .start_tgl_a(start_tgl), .seed_ref(seed_ref),
    .seed_win(seed_win), .mon_exp_a(mon_exp), .mon_tag_a(mon_tag),
    .verdict_tgl(verdict_tgl), .verdict_err(verdict_err), .heartbeat(heartbeat));

  clkmon_mon_side #(.CW(W1)) u_mon (
    .clk(mon_clk), .rst_n(rst_n), .start_tgl_a(start_tgl), .seed(seed_mon),
    .exp_tgl(mon_exp), .run_tag(mon_tag));
endmodule

// File: tb/tb_clkmon_top.sv
`timescale 1ns/1ps
module tb_clkmon_top;
  localparam logic [7:0] A_CTRL = 8'h00, A_SREF = 8'h04, A_SWIN = 8'h08,
                         A_SMON = 8'h0C, A_TMO = 8'h10, A_STAT = 8'h14;

  logic sys_clk = 0, ref_clk = 0, mon_clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_done, err_out;
  int ref_half = 5, mon_half = 5;
  bit ref_on = 1, mon_on = 1;
  int n_checks = 0, n_errs = 0, irq_cnt = 0, cyc = 0;

  clkmon_top dut (.sys_clk(sys_clk), .rst_n(rst_n), .ref_clk(ref_clk), .mon_clk(mon_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_done(irq_done), .err_out(err_out));

  always #5 sys_clk = ~sys_clk;
  always begin
    if (ref_on) #(ref_half) ref_clk = ~ref_clk;
    else        #7;
  end
  always begin
    if (mon_on) #(mon_half) mon_clk = ~mon_clk;
    else        #7;
  end

  always @(negedge sys_clk) begin
    cyc++;
    if (irq_done) irq_cnt++;
    if (cyc > 190000) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge sys_clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge sys_clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge sys_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // verdict model: 0 pass, 1 error, 2 too close to call
  function automatic int f_predict(int s0, int sv, int s1, int pr, int pm);
    int t_open, t_close, t_mon, m;
    t_open  = (s0 + 3) * pr;
    t_close = (s0 + sv + 3) * pr;
    t_mon   = (s1 + 3) * pm + 3 * pr;
    m       = 3 * (pr + pm) + 10;
    if (t_mon < t_open - m) return 1;
    if (t_mon > t_open + m && t_mon < t_close - m) return 0;
    if (t_mon > t_close + m) return 1;
    return 2;
  endfunction

  // returns 0 done, 1 error, 3 no verdict
  task automatic run(input int s0, input int sv, input int s1, output int res);
    logic [31:0] st;
    wr(A_STAT, 32'h3);
    wr(A_SREF, s0); wr(A_SWIN, sv); wr(A_SMON, s1);
    wr(A_CTRL, 32'h1);
    res = 3;
    for (int k = 0; k < 40000; k++) begin
      rd(A_STAT, st);
      if (st[1:0] != 2'b00) begin
        res = st[1] ? 0 : 1;
        break;
      end
    end
    repeat (2) @(negedge sys_clk);
  endtask

  initial begin
    logic [31:0] v;
    int res, i0, acc;
    void'($urandom(32'd2024));
    repeat (5) @(negedge sys_clk);
    rst_n = 1;
    repeat (3) @(negedge sys_clk);

    // R1 reset values
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_SREF, v); check("R1 ref seed", v, 0);
    rd(A_SMON, v); check("R1 mon seed", v, 0);
    rd(A_TMO, v);  check("R1 timeout", v, 1024);
    check("R1 irq_done", irq_done, 0);
    check("R1 err_out", err_out, 0);

    // R2 directed pass, equal clocks
    i0 = irq_cnt;
    run(200, 100, 250, res);
    check("R2 pass verdict", res, 0);
    check("R2 one irq pulse", irq_cnt - i0, 1);
    check("R2 err_out low", err_out, 0);

    // R6 write-1-to-clear: bit0 leaves done, bit1 clears it
    wr(A_STAT, 32'h1); rd(A_STAT, v); check("R6 done kept", v[1], 1);
    wr(A_STAT, 32'h2); rd(A_STAT, v); check("R6 done cleared", v, 0);

    // R3 early monitor expiry
    i0 = irq_cnt;
    run(300, 50, 100, res);
    check("R3 early error", res, 1);
    check("R3 no irq", irq_cnt - i0, 0);
    check("R5 err_out high", err_out, 1);
    wr(A_STAT, 32'h1);
    check("R5 err_out cleared", err_out, 0);

    // R4 late monitor expiry
    run(100, 40, 400, res);
    check("R4 late error", res, 1);

    // R4 missing monitor clock, then stale expiry from that run must not matter
    mon_on = 0;
    run(120, 60, 150, res);
    check("R4 missing mon clock", res, 1);
    mon_on = 1;
    repeat (50) @(negedge sys_clk);
    run(400, 30, 2000, res);
    check("R4 stale expiry ignored", res, 1);
    run(200, 100, 250, res);
    check("R2 pass after stale run", res, 0);

    // R7 and R8: start and config writes while busy are ignored
    i0 = irq_cnt;
    wr(A_STAT, 32'h3);
    wr(A_SREF, 200); wr(A_SWIN, 100); wr(A_SMON, 250);
    wr(A_CTRL, 32'h1);
    wr(A_SMON, 5); wr(A_TMO, 3); wr(A_CTRL, 32'h1);
    rd(A_SMON, v); check("R8 mon seed held", v, 250);
    rd(A_TMO, v);  check("R8 timeout held", v, 1024);
    rd(A_STAT, v); check("R6 busy bit", v[2], 1);
    for (int k = 0; k < 20000; k++) begin
      rd(A_STAT, v);
      if (v[1:0] != 0) break;
    end
    check("R7 original run passes", v[1:0], 2);
    repeat (1500) @(negedge sys_clk);
    rd(A_STAT, v); check("R7 single outcome", v, 2);
    check("R7 one irq", irq_cnt - i0, 1);

    // randomized periods and seeds
    acc = 0;
    for (int t = 0; t < 300 && acc < 16; t++) begin
      int hr, hm, pr, pm, s0, sv, s1, cls, tgt, exp;
      hr = $urandom_range(3, 12); hm = $urandom_range(3, 12);
      pr = 2 * hr; pm = 2 * hm;
      s0 = $urandom_range(50, 300); sv = $urandom_range(30, 150);
      cls = $urandom_range(0, 2);
      if (cls == 0)      tgt = (s0 + 3) * pr / 2;
      else if (cls == 1) tgt = (s0 + 3 + sv / 2) * pr;
      else               tgt = (s0 + sv + 3) * pr + 300;
      s1 = (tgt - 3 * pr) / pm - 3;
      if (s1 < 4) s1 = 4;
      exp = f_predict(s0, sv, s1, pr, pm);
      if (exp == 2) continue;
      ref_half = hr; mon_half = hm;
      i0 = irq_cnt;
      run(s0, sv, s1, res);
      if (exp == 0) check("R2 random pass", res, 0);
      else          check(s1 * pm < s0 * pr ? "R3 random early" : "R4 random late", res, 1);
      check("R5 irq vs verdict", irq_cnt - i0, exp == 0 ? 1 : 0);
      acc++;
    end
    ref_half = 5; mon_half = 5;

    // R9 missing reference clock, short timeout
    wr(A_TMO, 64);
    ref_on = 0;
    run(100, 50, 120, res);
    check("R9 timeout error", res, 1);
    check("R9 err_out", err_out, 1);
    ref_on = 1;
    rst_n = 0; repeat (4) @(negedge sys_clk); rst_n = 1;
    repeat (10) @(negedge sys_clk);
    run(200, 100, 250, res);
    check("R2 pass after reset", res, 0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule